// File: doc/BRIEF.md
# Configuration Space Access Sequencer

This block serves a local host that wants byte, halfword or word reads and writes of device configuration space behind a bridge. The bridge exposes only two 32-bit registers: an address register, which must be loaded first, and a data register, which then carries the transfer. The bridge moves whole 32-bit words only, so the sequencer turns each host request into a short series of register-bus cycles. Each request starts with the address word. A read then fetches the data word and cuts out the requested part. A word write stores the data word directly. A narrow write fetches the word, merges the new bytes into it and stores the result.

The data path presents each configuration word in big-endian order. Offset 0 names the most significant byte, and the halfword at offset 0 is the upper half of the word. Requests addressed beyond the supported range are refused at once and start no bus cycle. A target that does not answer within a programmable number of cycles ends the request with a timeout status. In that case a read returns all-ones at its width, and a sticky error flag is raised. The lock output is held from acceptance to completion, so no other master can reload the address register between the two steps.

Top module: `cfg_seq`

## Requirements
- R1: The first bus cycle of every accepted in-range request writes address BASE+0x500 with the word {8'h00, bus, devfn, offset[7:2], 2'b0x}, where bit 0 is the type bit. Every later bus cycle of the same request uses BASE+0x504.
- R2: Bit 0 of the address word is 1 when the bus number is non-zero and 0 for bus 0.
- R3: A request with bus > 7 or devfn > 127 makes no bus cycle. It completes in the cycle after acceptance with status 2'b01. A read returns 32'hFF (byte), 32'hFFFF (half) or 32'hFFFFFFFF (word), and a write returns 0.
- R4: A byte read (req_size 2'b00) returns, zero-extended, bits [8*k+7:8*k] of the fetched word, where k = 3 - offset[1:0].
- R5: A halfword read (req_size 2'b01) returns, zero-extended, bits [31:16] of the fetched word when offset[1] is 0 and bits [15:0] when it is 1.
- R6: A word read (req_size 2'b10) makes exactly two bus cycles: the address write, then one data read. It returns the fetched word unchanged with status 2'b00.
- R7: A byte or halfword write makes three bus cycles: the address write, a data read, then a data write. The written word equals the fetched word with only the lane of R4 or R5 replaced by req_wdata[7:0] or req_wdata[15:0].
- R8: A word write makes exactly two bus cycles: the address write, then a data write of req_wdata. A write completes with status 2'b00 and return data 0.
- R9: A bus cycle that sees m_error, or that sees no m_ready for TIMEOUT_CYCLES cycles, aborts the request with status 2'b10. A read then returns all-ones at its width as in R3. sticky_err goes high and stays high until reset.
- R10: req_ready is high only while no request is in progress. busy is high from the cycle after acceptance until completion. done is a single-cycle pulse. While m_valid is high and no response has come, m_addr, m_write and m_wdata hold steady.
- R11: After reset, req_ready is 1 and busy, done, m_valid and sticky_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_bus | input | 8 | Bus number |
| req_devfn | input | 8 | Device/function number |
| req_offset | input | 8 | Register byte offset |
| req_wdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 00 ok, 01 not found, 10 timeout |
| done_rdata | output | 32 | Read result, zero-extended |
| busy | output | 1 | Sequence in progress (address lock) |
| sticky_err | output | 1 | Timeout seen since reset |
| m_valid | output | 1 | Register-bus cycle request |
| m_write | output | 1 | Register-bus write |
| m_addr | output | AW | Register-bus address |
| m_wdata | output | 32 | Register-bus write data |
| m_rdata | input | 32 | Register-bus read data |
| m_ready | input | 1 | Register-bus cycle complete |
| m_error | input | 1 | Register-bus cycle failed |

## Verification
A refused request makes done visible in the first cycle after the accepting edge. Each bus cycle ends on the edge where m_ready or m_error is sampled, and the next step's m_valid appears right after that edge. done follows one cycle after the last bus cycle, or TIMEOUT_CYCLES cycles after a silent cycle began. The bench drives requests and the bridge model on the falling edge and samples on the falling edge. It polls for done with a bounded loop, and it checks that done and busy have dropped exactly one cycle after the pulse. The model logs every bus cycle, so the count, order, addresses and data of the steps are compared after each request and not by cycle position.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
    localparam int WORD_W = 32;
    localparam int NLANES = WORD_W / 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_RD,
        S_WR,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'b00,
        ST_NOTFOUND = 2'b01,
        ST_TIMEOUT  = 2'b10
    } status_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    function automatic logic [WORD_W-1:0] fill_ones(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: fill_ones = 32'h0000_00FF;
            SZ_HALF: fill_ones = 32'h0000_FFFF;
            default: fill_ones = '1;
        endcase
    endfunction
endpackage

// File: rtl/cfgseq_addr_fmt.sv
module cfgseq_addr_fmt #(
    parameter int MAX_BUS   = 7,
    parameter int MAX_DEVFN = 127
) (
    input  logic [7:0]  bus_i,
    input  logic [7:0]  devfn_i,
    input  logic [7:0]  offset_i,
    output logic [31:0] addr_word_o,
    output logic        in_range_o
);
    localparam logic [7:0] BUS_LIM   = 8'(MAX_BUS);
    localparam logic [7:0] DEVFN_LIM = 8'(MAX_DEVFN);

    always_comb begin
        addr_word_o = {8'h00, bus_i, devfn_i, offset_i[7:2], 1'b0, (bus_i != 8'h00)};
        in_range_o  = (bus_i <= BUS_LIM) && (devfn_i <= DEVFN_LIM);
    end
endmodule

// File: rtl/cfgseq_lanes.sv
module cfgseq_lanes
    import cfgseq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [7:0]        offset_i,
    input  logic [1:0]        size_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] extract_o,
    output logic [WORD_W-1:0] merged_o
);
    logic [1:0]        lane;
    logic              hsel;
    logic [NLANES-1:0] lane_en;

    assign lane = offset_i[1:0] ^ 2'b11;
    assign hsel = offset_i[1] ^ 1'b1;

    always_comb begin
        case (size_i)
            SZ_BYTE: extract_o = {24'h0, word_i[8*lane +: 8]};
            SZ_HALF: extract_o = {16'h0, word_i[16*hsel +: 16]};
            default: extract_o = word_i;
        endcase
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        logic [7:0] src;
        always_comb begin
            case (size_i)
                SZ_BYTE: begin
                    lane_en[g] = (lane == 2'(g));
                    src        = wdata_i[7:0];
                end
                SZ_HALF: begin
                    lane_en[g] = (hsel == 1'((g / 2) % 2));
                    src        = wdata_i[8*(g % 2) +: 8];
                end
                default: begin
                    lane_en[g] = 1'b1;
                    src        = wdata_i[8*g +: 8];
                end
            endcase
        end
        assign merged_o[8*g +: 8] = lane_en[g] ? src : word_i[8*g +: 8];
    end
endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfgseq_pkg::*;
#(
    parameter int          AW             = 16,
    parameter logic [15:0] BRIDGE_BASE    = 16'h2000,
    parameter int          TIMEOUT_CYCLES = 256,
    parameter int          MAX_BUS        = 7,
    parameter int          MAX_DEVFN      = 127
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [7:0]    req_bus,
    input  logic [7:0]    req_devfn,
    input  logic [7:0]    req_offset,
    input  logic [31:0]   req_wdata,
    output logic          done,
    output logic [1:0]    done_status,
    output logic [31:0]   done_rdata,
    output logic          busy,
    output logic          sticky_err,
    output logic          m_valid,
    output logic          m_write,
    output logic [AW-1:0] m_addr,
    output logic [31:0]   m_wdata,
    input  logic [31:0]   m_rdata,
    input  logic          m_ready,
    input  logic          m_error
);
    localparam int          CW       = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYCLES - 1);
    localparam logic [AW-1:0] ADDR_REG = AW'(BRIDGE_BASE) + AW'(16'h0500);
    localparam logic [AW-1:0] DATA_REG = AW'(BRIDGE_BASE) + AW'(16'h0504);

    typedef struct packed {
        seq_state_e  st;
        logic        wr;
        logic [1:0]  sz;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic [7:0]  off;
        logic [31:0] wdata;
        logic [31:0] word;
        logic [CW-1:0] cnt;
        logic        done;
        status_e     status;
        logic [31:0] rdata;
        logic        sticky;
    } regs_t;

    regs_t r_d, r_q;

    logic [7:0]  fmt_bus, fmt_devfn, fmt_off;
    logic [31:0] addr_word;
    logic        in_range;
    logic [31:0] lane_extract, lane_merged;
    logic        resp;

    assign fmt_bus   = (r_q.st == S_IDLE) ? req_bus    : r_q.bus;
    assign fmt_devfn = (r_q.st == S_IDLE) ? req_devfn  : r_q.devfn;
    assign fmt_off   = (r_q.st == S_IDLE) ? req_offset : r_q.off;

    cfgseq_addr_fmt #(
        .MAX_BUS  (MAX_BUS),
        .MAX_DEVFN(MAX_DEVFN)
    ) u_fmt (
        .bus_i      (fmt_bus),
        .devfn_i    (fmt_devfn),
        .offset_i   (fmt_off),
        .addr_word_o(addr_word),
        .in_range_o (in_range)
    );

    cfgseq_lanes u_lanes (
        .word_i   (m_rdata),
        .offset_i (r_q.off),
        .size_i   (r_q.sz),
        .wdata_i  (r_q.wdata),
        .extract_o(lane_extract),
        .merged_o (lane_merged)
    );

    assign resp = m_ready | m_error;

    always_comb begin
        m_valid = (r_q.st == S_ADDR) || (r_q.st == S_RD) || (r_q.st == S_WR);
        m_write = (r_q.st != S_RD);
        m_addr  = (r_q.st == S_ADDR) ? ADDR_REG : DATA_REG;
        m_wdata = (r_q.st == S_ADDR) ? addr_word : r_q.word;
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.wr    = req_write;
                    r_d.sz    = req_size;
                    r_d.bus   = req_bus;
                    r_d.devfn = req_devfn;
                    r_d.off   = req_offset;
                    r_d.wdata = req_wdata;
                    r_d.cnt   = '0;
                    if (in_range) begin
                        r_d.st = S_ADDR;
                    end else begin
                        r_d.st     = S_DONE;
                        r_d.done   = 1'b1;
                        r_d.status = ST_NOTFOUND;
                        r_d.rdata  = req_write ? 32'h0 : fill_ones(req_size);
                    end
                end
            end
            S_ADDR, S_RD, S_WR: begin
                if (resp && !m_error) begin
                    r_d.cnt = '0;
                    if (r_q.st == S_ADDR) begin
                        if (r_q.wr && r_q.sz[1]) begin
                            r_d.st   = S_WR;
                            r_d.word = r_q.wdata;
                        end else begin
                            r_d.st = S_RD;
                        end
                    end else if (r_q.st == S_RD && r_q.wr) begin
                        r_d.st   = S_WR;
                        r_d.word = lane_merged;
                    end else begin
                        r_d.st     = S_DONE;
                        r_d.done   = 1'b1;
                        r_d.status = ST_OK;
                        r_d.rdata  = r_q.wr ? 32'h0 : lane_extract;
                    end
                end else if (m_error || r_q.cnt == CNT_LAST) begin
                    r_d.st     = S_DONE;
                    r_d.done   = 1'b1;
                    r_d.status = ST_TIMEOUT;
                    r_d.rdata  = r_q.wr ? 32'h0 : fill_ones(r_q.sz);
                    r_d.sticky = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.st     <= S_IDLE;
            r_q.status <= ST_OK;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == S_IDLE);
    assign busy        = (r_q.st != S_IDLE);
    assign done        = r_q.done;
    assign done_status = r_q.status;
    assign done_rdata  = r_q.rdata;
    assign sticky_err  = r_q.sticky;

    // R3
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_bus > 8'(MAX_BUS) || req_devfn > 8'(MAX_DEVFN)))
        |=> (done && done_status == 2'b01 && !m_valid));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !resp && r_q.cnt != CNT_LAST)
        |=> (m_valid && $stable(m_addr) && $stable(m_write) && $stable(m_wdata)));

    // R9
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_err |=> sticky_err);

    // R1
    first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !(req_bus > 8'(MAX_BUS) || req_devfn > 8'(MAX_DEVFN)))
        |=> (m_valid && m_write && m_addr == ADDR_REG));

    // R2
    type_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_addr == ADDR_REG) |-> (m_wdata[0] == (m_wdata[23:16] != 8'h00)));
endmodule

// File: tb/sim_cfg_seq.sv
`timescale 1ns/1ps
module sim_cfg_seq;
    localparam logic [15:0] ADDR_REG = 16'h2500;
    localparam logic [15:0] DATA_REG = 16'h2504;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [7:0]  req_bus = 8'h0, req_devfn = 8'h0, req_offset = 8'h0;
    logic [31:0] req_wdata = 32'h0;
    logic        req_ready, done, busy, sticky_err;
    logic [1:0]  done_status;
    logic [31:0] done_rdata;
    logic        m_valid, m_write;
    logic [15:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata = 32'h0;
    logic        m_ready = 1'b0, m_error = 1'b0;

    always #2 clk = ~clk;

    cfg_seq u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_size(req_size), .req_bus(req_bus), .req_devfn(req_devfn),
        .req_offset(req_offset), .req_wdata(req_wdata),
        .done(done), .done_status(done_status), .done_rdata(done_rdata),
        .busy(busy), .sticky_err(sticky_err),
        .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_error(m_error)
    );

    int errors = 0;
    int checks = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bridge model
    logic [31:0] mem [16];
    logic [31:0] shadow [16];
    logic [31:0] areg = 32'h0;
    logic        mute = 1'b0, err_mode = 1'b0;
    logic        lg_wr [8];
    logic [15:0] lg_addr [8];
    logic [31:0] lg_data [8];
    int          lg_n = 0;

    function automatic int idx_of(input logic [31:0] a);
        return int'({a[9:8], a[3:2]});
    endfunction

    always @(negedge clk) begin
        if (m_valid && !m_ready && !m_error && !mute) begin
            m_ready <= !err_mode;
            m_error <= err_mode;
            if (lg_n < 8) begin
                lg_wr[lg_n]   = m_write;
                lg_addr[lg_n] = m_addr;
                lg_data[lg_n] = m_wdata;
            end
            lg_n = lg_n + 1;
            if (!err_mode) begin
                if (m_write && m_addr == ADDR_REG) areg = m_wdata;
                else if (m_write) mem[idx_of(areg)] = m_wdata;
                else m_rdata <= mem[idx_of(areg)];
            end
        end else begin
            m_ready <= 1'b0;
            m_error <= 1'b0;
        end
    end

    logic [1:0]  got_status;
    logic [31:0] got_rdata;
    logic        got_done;

    task automatic run_req(input logic wr, input logic [1:0] sz, input logic [7:0] bus,
                           input logic [7:0] dfn, input logic [7:0] off,
                           input logic [31:0] wd, input string tag);
        int n;
        lg_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_bus = bus; req_devfn = dfn; req_offset = off; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0 && busy == 1'b1, {tag, " R10 locked after accept"},
            {30'h0, req_ready, busy}, 32'h1);
        n = 0;
        while (!done && n < 1000) begin
            @(negedge clk);
            n++;
        end
        got_done   = done;
        got_status = done_status;
        got_rdata  = done_rdata;
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0 && req_ready == 1'b1,
            {tag, " R10 pulse ends, idle"}, {29'h0, done, busy, req_ready}, 32'h1);
    endtask

    typedef struct packed {
        logic       wr;
        logic [1:0] sz;
        logic [7:0] bus;
        logic [7:0] devfn;
        logic [7:0] off;
        logic [31:0] wd;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd2, 8'd0, 8'h00, 8'h00, 32'h0},
        '{1'b0, 2'd0, 8'd0, 8'h01, 8'h01, 32'h0},
        '{1'b0, 2'd0, 8'd0, 8'h01, 8'h03, 32'h0},
        '{1'b0, 2'd1, 8'd0, 8'h02, 8'h02, 32'h0},
        '{1'b0, 2'd1, 8'd0, 8'h02, 8'h00, 32'h0},
        '{1'b1, 2'd0, 8'd0, 8'h03, 8'h05, 32'hFFFF_FFAB},
        '{1'b0, 2'd2, 8'd0, 8'h03, 8'h04, 32'h0},
        '{1'b1, 2'd1, 8'd3, 8'h10, 8'h0A, 32'h1234_BEEF},
        '{1'b0, 2'd2, 8'd3, 8'h10, 8'h08, 32'h0},
        '{1'b1, 2'd2, 8'd0, 8'h01, 8'h0C, 32'h1234_5678},
        '{1'b0, 2'd2, 8'd0, 8'h01, 8'h0C, 32'h0},
        '{1'b0, 2'd0, 8'd8, 8'h00, 8'h00, 32'h0},
        '{1'b0, 2'd1, 8'd0, 8'h80, 8'h00, 32'h0},
        '{1'b1, 2'd2, 8'd9, 8'h00, 8'h00, 32'h5555_5555},
        '{1'b0, 2'd2, 8'd7, 8'h7F, 8'hFE, 32'h0}
    };

    function automatic logic [31:0] ones_w(input logic [1:0] sz);
        return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
    endfunction

    initial begin : wdog
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin
            mem[i]    = {8'h10 + 8'(i), 8'h20 + 8'(i), 8'h30 + 8'(i), 8'h40 + 8'(i)};
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready && !busy && !done && !m_valid && !sticky_err, "R11 reset state",
            {27'h0, req_ready, busy, done, m_valid, sticky_err}, 32'h10);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t        c;
            logic        inr;
            logic [31:0] aw, w, expd, merged;
            int          ix, k;
            string       tg;
            c   = VECS[v];
            tg  = $sformatf("vec%0d", v);
            inr = (c.bus <= 8'd7) && (c.devfn <= 8'd127);
            aw  = {8'h0, c.bus, c.devfn, c.off[7:2], 1'b0, (c.bus != 8'h0)};
            ix  = idx_of(aw);
            w   = shadow[ix];
            merged = w;
            k = 3 - int'(c.off[1:0]);
            if (c.sz == 2'd0) merged[8*k +: 8] = c.wd[7:0];
            else if (c.sz == 2'd1) begin
                if (c.off[1]) merged[15:0] = c.wd[15:0];
                else merged[31:16] = c.wd[15:0];
            end else merged = c.wd;
            if (c.sz == 2'd0) expd = {24'h0, w[8*k +: 8]};
            else if (c.sz == 2'd1) expd = c.off[1] ? {16'h0, w[15:0]} : {16'h0, w[31:16]};
            else expd = w;

            run_req(c.wr, c.sz, c.bus, c.devfn, c.off, c.wd, tg);
            chk(got_done, {tg, " R10 done seen"}, {31'h0, got_done}, 32'h1);
            if (!inr) begin
                chk(got_status == 2'b01, {tg, " R3 not-found status"}, {30'h0, got_status}, 32'h1);
                chk(got_rdata == (c.wr ? 32'h0 : ones_w(c.sz)), {tg, " R3 fill value"},
                    got_rdata, c.wr ? 32'h0 : ones_w(c.sz));
                chk(lg_n == 0, {tg, " R3 no bus cycle"}, 32'(lg_n), 32'h0);
            end else begin
                chk(got_status == 2'b00, {tg, " R6 ok status"}, {30'h0, got_status}, 32'h0);
                chk(lg_wr[0] && lg_addr[0] == ADDR_REG && lg_data[0] == aw,
                    {tg, " R1 R2 address step"}, lg_data[0], aw);
                chk(lg_addr[1] == DATA_REG, {tg, " R1 data register"}, {16'h0, lg_addr[1]},
                    {16'h0, DATA_REG});
                if (!c.wr) begin
                    chk(lg_n == 2 && !lg_wr[1], {tg, " R6 two cycles"}, 32'(lg_n), 32'h2);
                    chk(got_rdata == expd, {tg, (c.sz == 2'd0) ? " R4 byte" :
                        (c.sz == 2'd1) ? " R5 half" : " R6 word"}, got_rdata, expd);
                end else if (c.sz == 2'd2) begin
                    chk(lg_n == 2 && lg_wr[1] && lg_data[1] == c.wd, {tg, " R8 direct write"},
                        lg_data[1], c.wd);
                    chk(got_rdata == 32'h0, {tg, " R8 write rdata"}, got_rdata, 32'h0);
                    shadow[ix] = merged;
                end else begin
                    chk(lg_n == 3 && !lg_wr[1] && lg_wr[2] && lg_addr[2] == DATA_REG,
                        {tg, " R7 three-step order"}, 32'(lg_n), 32'h3);
                    chk(lg_data[2] == merged, {tg, " R7 merged word"}, lg_data[2], merged);
                    shadow[ix] = merged;
                end
            end
        end

        // R9 silent target, word read
        chk(sticky_err == 1'b0, "R9 sticky clear before timeout", {31'h0, sticky_err}, 32'h0);
        mute = 1'b1;
        run_req(1'b0, 2'd2, 8'd0, 8'h04, 8'h00, 32'h0, "to_word");
        chk(got_status == 2'b10, "R9 timeout status", {30'h0, got_status}, 32'h2);
        chk(got_rdata == 32'hFFFF_FFFF, "R9 timeout word all-ones", got_rdata, 32'hFFFF_FFFF);
        chk(sticky_err == 1'b1, "R9 sticky set", {31'h0, sticky_err}, 32'h1);
        run_req(1'b0, 2'd0, 8'd1, 8'h04, 8'h03, 32'h0, "to_byte");
        chk(got_rdata == 32'hFF && got_status == 2'b10, "R9 timeout byte fill", got_rdata, 32'hFF);
        mute = 1'b0;
        err_mode = 1'b1;
        run_req(1'b0, 2'd1, 8'd0, 8'h04, 8'h00, 32'h0, "err_half");
        chk(got_rdata == 32'hFFFF && got_status == 2'b10, "R9 bus error half fill",
            got_rdata, 32'hFFFF);
        chk(lg_n == 1, "R9 error aborts after one cycle", 32'(lg_n), 32'h1);
        err_mode = 1'b0;
        run_req(1'b0, 2'd2, 8'd0, 8'h00, 8'h00, 32'h0, "after_err");
        chk(got_status == 2'b00 && got_rdata == shadow[0], "R6 read after error", got_rdata,
            shadow[0]);
        chk(sticky_err == 1'b1, "R9 sticky held", {31'h0, sticky_err}, 32'h1);

        // R11 reset clears sticky
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sticky_err && req_ready && !busy, "R11 reset clears sticky",
            {29'h0, sticky_err, req_ready, busy}, 32'h2);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule